// File: doc/BRIEF.md
# Burst-of-Two Dual-Port SRAM Model

This block is a synthesizable, cycle-level model of a double-pumped static memory. It has separate read and write data buses. Every access moves exactly two words in one period of the input clock pair. Commands are sampled on the rising edge of `clk_k`. The second write word and the write address are sampled on the rising edge of its complement `clk_kn`. A read and a write may both start in the same period. Storage is an inferred register array. Each address holds one two-word location: word 0 sits in the low `DATA_W` bits and word 1 in the high `DATA_W` bits.

Read data comes back on an output clock pair. The first word is launched on the rising edge of `clk_cn` and the second on the following rising edge of `clk_c`. When both output clocks are held high, the input pair takes over that role. An echo clock pair always follows whichever pair is in use, whether or not data is moving. `rd_valid` marks the two beats that carry data.

The write path is a two-state machine. `WR_IDLE` moves to `WR_SECOND` on a `clk_k` edge that sees `wr_n` low ("write start"). `WR_SECOND` commits the merged burst on the next `clk_kn` edge. It then returns to `WR_IDLE` on the next `clk_k` edge, or stays in `WR_SECOND` if another write starts ("back-to-back write"). Reset forces `WR_IDLE`.

Top module: `burst2_sram`

## Requirements
- R1: A write starts when `wr_n` is low at a `clk_k` rising edge. `wdata` at that edge becomes word 0. `wdata` and `addr` at the next `clk_kn` rising edge give word 1 and the location. Both words are stored at that location.
- R2: `wbe_n[i]` is active low and guards bits [9i+8:9i] of the beat it is sampled with. It is sampled once per beat: at the `clk_k` edge for word 0 and at the `clk_kn` edge for word 1. A lane whose enable is high keeps its stored value.
- R3: A read starts when `rd_n` is low at a `clk_k` rising edge. `addr` is taken at that same edge. Word 0 is returned first, then word 1.
- R4: Word 0 appears on the first first-beat reference rising edge that comes RD_DELAY + 0.5 periods after the read command edge. Word 1 appears on the following second-beat reference rising edge. `rd_valid` is high for exactly those two beats.
- R5: Whenever `rd_valid` is low, `rdata` is all zero.
- R6: When a read and a write to the same location start in the same period, the read returns the contents from before that write. A read started in the next period returns the new contents.
- R7: `addr` and `wdata` have no effect in a period where neither strobe is low, and `addr` at a `clk_kn` edge has no effect unless a write started half a period earlier.
- R8: When `clk_c` and `clk_cn` are both high, `clk_kn` and `clk_k` serve as the first-beat and second-beat references. Otherwise `clk_cn` and `clk_c` serve, and the output timing follows them.
- R9: `echo_clk_n` follows the first-beat reference and `echo_clk` follows the second-beat reference, including when the bus is idle.
- R10: Reads in consecutive periods return an unbroken stream of four beats, in command order.
- R11: During and after reset, `rd_valid` is low and `rdata` is zero until a read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock, command and first write beat |
| clk_kn | input | 1 | Complement of clk_k, write address and second write beat |
| clk_c | input | 1 | Output reference for the second read beat, held high to select clk_k |
| clk_cn | input | 1 | Output reference for the first read beat, held high to select clk_kn |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Shared read/write location address |
| wdata | input | DATA_W | Write data, one word per beat |
| wbe_n | input | DATA_W/9 | Active-low byte-lane write enables, one per 9-bit lane |
| rdata | output | DATA_W | Read data, zero when idle |
| rd_valid | output | 1 | High during the two read beats |
| echo_clk | output | 1 | Echo of the second-beat reference |
| echo_clk_n | output | 1 | Echo of the first-beat reference |

## Verification
The assertions assume four things about the inputs:
- `clk_kn` is the exact complement of `clk_k`.
- The output pair is either held high or complementary, and trails the input pair by less than half a period.
- The output-reference choice changes only while reset is held.
- Inputs settle well away from both input-clock edges.

The latency and pairing checks compare the beat-valid value seen just before each echo edge with the command history taken on `clk_k`. That comparison only holds under these assumptions. The stimulus drives every input a quarter period after the opposite edge. It switches the output pair between tied-high and a 2 ns lag only with reset asserted.

// File: rtl/qb_sram_pkg.sv
`timescale 1ns/1ps
package qb_sram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_SECOND = 1'b1
    } wr_state_e;
endpackage

// File: rtl/qb_wr_capture.sv
`timescale 1ns/1ps
module qb_wr_capture
    import qb_sram_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk_k,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wbe_n,
    output logic              commit,
    output logic [DATA_W-1:0] beat0_data,
    output logic [LANES-1:0]  beat0_be_n
);
    wr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state: a low strobe at clk_k always opens the second half
    always_comb begin
        state_d = WR_IDLE;
        unique case (state_q)
            WR_IDLE:   state_d = wr_n ? WR_IDLE : WR_SECOND;
            WR_SECOND: state_d = wr_n ? WR_IDLE : WR_SECOND;
        endcase
    end

    // outputs
    always_comb begin
        commit = (state_q == WR_SECOND);
    end

    // first beat data and lane enables
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            beat0_data <= '0;
            beat0_be_n <= '1;
        end else if (!wr_n) begin
            beat0_data <= wdata;
            beat0_be_n <= wbe_n;
        end
    end
endmodule

// File: rtl/qb_store_array.sv
`timescale 1ns/1ps
module qb_store_array
    import qb_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic                clk_kn,
    input  logic                commit,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   beat0_data,
    input  logic [LANES-1:0]    beat0_be_n,
    input  logic [DATA_W-1:0]   beat1_data,
    input  logic [LANES-1:0]    beat1_be_n,
    output logic [2*DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2*DATA_W-1:0] mem [DEPTH];
    logic [2*DATA_W-1:0] old_word;
    logic [2*DATA_W-1:0] merged;

    assign old_word = mem[addr];
    assign rd_word  = old_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO0 = g * LANE_W;
        localparam int LO1 = DATA_W + g * LANE_W;
        assign merged[LO0 +: LANE_W] = beat0_be_n[g] ? old_word[LO0 +: LANE_W]
                                                     : beat0_data[g*LANE_W +: LANE_W];
        assign merged[LO1 +: LANE_W] = beat1_be_n[g] ? old_word[LO1 +: LANE_W]
                                                     : beat1_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_kn) begin
        if (commit) mem[addr] <= merged;
    end
endmodule

// File: rtl/qb_rd_return.sv
`timescale 1ns/1ps
module qb_rd_return #(
    parameter int DATA_W   = 18,
    parameter int RD_DELAY = 1
) (
    input  logic                clk_k,
    input  logic                ref_first,
    input  logic                ref_second,
    input  logic                rst_n,
    input  logic                rd_go,
    input  logic [2*DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0]   rdata,
    output logic                rd_valid
);
    localparam int STAGES = RD_DELAY + 1;
    localparam int LAST   = STAGES - 1;

    logic [STAGES-1:0]   pv;
    logic [2*DATA_W-1:0] pw [STAGES];
    logic                va, hv, vb;
    logic [DATA_W-1:0]   qa, hw, qb;

    // command-clock delay line
    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            pv <= '0;
            for (int i = 0; i < STAGES; i++) pw[i] <= '0;
        end else begin
            pv[0] <= rd_go;
            if (rd_go) pw[0] <= rd_word;
            for (int i = 1; i < STAGES; i++) begin
                pv[i] <= pv[i-1];
                pw[i] <= pw[i-1];
            end
        end
    end

    // first-beat launch, second word held for the other edge
    always_ff @(posedge ref_first or negedge rst_n) begin
        if (!rst_n) begin
            va <= 1'b0;
            qa <= '0;
            hv <= 1'b0;
            hw <= '0;
        end else begin
            va <= pv[LAST];
            qa <= pv[LAST] ? pw[LAST][DATA_W-1:0] : '0;
            hv <= pv[LAST];
            hw <= pv[LAST] ? pw[LAST][2*DATA_W-1:DATA_W] : '0;
        end
    end

    // second-beat launch
    always_ff @(posedge ref_second or negedge rst_n) begin
        if (!rst_n) begin
            vb <= 1'b0;
            qb <= '0;
        end else begin
            vb <= hv;
            qb <= hw;
        end
    end

    assign rdata    = ref_second ? qb : qa;
    assign rd_valid = ref_second ? vb : va;
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram
    import qb_sram_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 18,
    parameter int RD_DELAY = 1
) (
    input  logic                       clk_k,
    input  logic                       clk_kn,
    input  logic                       clk_c,
    input  logic                       clk_cn,
    input  logic                       rst_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/LANE_W-1:0]   wbe_n,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rd_valid,
    output logic                       echo_clk,
    output logic                       echo_clk_n
);
    localparam int LANES = DATA_W / LANE_W;

    logic                c_tied;
    logic                ref_first, ref_second;
    logic                commit;
    logic [DATA_W-1:0]   beat0_data;
    logic [LANES-1:0]    beat0_be_n;
    logic [2*DATA_W-1:0] rd_word;

    // output-reference selection: both output clocks high selects the input pair
    assign c_tied     = clk_c & clk_cn;
    assign ref_first  = c_tied ? clk_kn : clk_cn;
    assign ref_second = c_tied ? clk_k  : clk_c;
    assign echo_clk   = ref_second;
    assign echo_clk_n = ref_first;

    qb_wr_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_wr (
        .clk_k      (clk_k),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .wdata      (wdata),
        .wbe_n      (wbe_n),
        .commit     (commit),
        .beat0_data (beat0_data),
        .beat0_be_n (beat0_be_n)
    );

    qb_store_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_mem (
        .clk_kn     (clk_kn),
        .commit     (commit),
        .addr       (addr),
        .beat0_data (beat0_data),
        .beat0_be_n (beat0_be_n),
        .beat1_data (wdata),
        .beat1_be_n (wbe_n),
        .rd_word    (rd_word)
    );

    qb_rd_return #(.DATA_W(DATA_W), .RD_DELAY(RD_DELAY)) u_rd (
        .clk_k      (clk_k),
        .ref_first  (ref_first),
        .ref_second (ref_second),
        .rst_n      (rst_n),
        .rd_go      (~rd_n),
        .rd_word    (rd_word),
        .rdata      (rdata),
        .rd_valid   (rd_valid)
    );
endmodule

// File: rtl/qb_sram_chk.sv
`timescale 1ns/1ps
module qb_sram_chk #(
    parameter int DATA_W   = 18,
    parameter int RD_DELAY = 1
) (
    input logic              clk_k,
    input logic              rst_n,
    input logic              rd_n,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rdata,
    input logic              echo_clk,
    input logic              echo_clk_n
);
    logic [RD_DELAY:0] hist;
    logic              lat_a;

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist[0] <= ~rd_n;
            for (int i = 1; i <= RD_DELAY; i++) hist[i] <= hist[i-1];
        end
    end

    always_ff @(posedge echo_clk_n or negedge rst_n) begin
        if (!rst_n) lat_a <= 1'b0;
        else        lat_a <= hist[RD_DELAY];
    end

    // R4
    read_latency_chk: assert property (@(posedge echo_clk) disable iff (!rst_n)
        rd_valid == lat_a);

    // R4
    beat_pair_chk: assert property (@(posedge echo_clk_n) disable iff (!rst_n)
        rd_valid == lat_a);

    // R5
    idle_first_zero_chk: assert property (@(posedge echo_clk) disable iff (!rst_n)
        !rd_valid |-> rdata == '0);

    // R5
    idle_second_zero_chk: assert property (@(posedge echo_clk_n) disable iff (!rst_n)
        !rd_valid |-> rdata == '0);
endmodule

bind burst2_sram qb_sram_chk #(.DATA_W(DATA_W), .RD_DELAY(RD_DELAY)) u_chk (
    .clk_k      (clk_k),
    .rst_n      (rst_n),
    .rd_n       (rd_n),
    .rd_valid   (rd_valid),
    .rdata      (rdata),
    .echo_clk   (echo_clk),
    .echo_clk_n (echo_clk_n)
);

// File: tb/burst2_sram_test.sv
`timescale 1ns/1ps
module burst2_sram_test;
    localparam int P      = 10;
    localparam int SKEW   = 2;
    localparam int AW     = 4;
    localparam int DW     = 18;
    localparam int LN     = 2;
    localparam int RD_DLY = 1;
    localparam int NVEC   = 6;

    // vector: addr[43:40] be0_n[39:38] be1_n[37:36] d0[35:18] d1[17:0]
    localparam logic [43:0] VEC [NVEC] = '{
        {4'h3, 2'b00, 2'b00, 18'h12345, 18'h2ABCD},
        {4'h3, 2'b01, 2'b11, 18'h3FFFF, 18'h00000},
        {4'h7, 2'b10, 2'b01, 18'h001FF, 18'h3FE00},
        {4'hF, 2'b11, 2'b11, 18'h15555, 18'h2AAAA},
        {4'h0, 2'b00, 2'b10, 18'h0F0F0, 18'h30303},
        {4'h9, 2'b11, 2'b00, 18'h11111, 18'h22222}
    };

    logic clk_k = 1'b0;
    logic clk_kn;
    logic c_lag;
    logic tied_mode = 1'b1;
    logic clk_c, clk_cn;
    logic rst_n = 1'b0;
    logic rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [LN-1:0] wbe_n = '1;
    logic [DW-1:0] rdata;
    logic rd_valid, echo_clk, echo_clk_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [2*DW-1:0] model [16];

    always #(P/2) clk_k = ~clk_k;
    assign clk_kn = ~clk_k;
    assign #SKEW c_lag = clk_k;
    assign clk_c  = tied_mode ? 1'b1 : c_lag;
    assign clk_cn = tied_mode ? 1'b1 : ~c_lag;

    burst2_sram #(.ADDR_W(AW), .DATA_W(DW), .RD_DELAY(RD_DLY)) uut (
        .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn),
        .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rd_valid(rd_valid),
        .echo_clk(echo_clk), .echo_clk_n(echo_clk_n)
    );

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [LN-1:0] be_n);
        logic [DW-1:0] r;
        for (int i = 0; i < LN; i++)
            r[i*9 +: 9] = be_n[i] ? old[i*9 +: 9] : nw[i*9 +: 9];
        return r;
    endfunction

    // one input-clock period of stimulus; read address at clk_k, write address at clk_kn
    task automatic cyc(input bit rd, input bit wr, input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [LN-1:0] b0, input logic [LN-1:0] b1);
        @(negedge clk_k); #(P/4);
        rd_n = !rd; wr_n = !wr; addr = ra; wdata = d0; wbe_n = b0;
        @(posedge clk_k); #(P/4);
        rd_n = 1'b1; wr_n = 1'b1; addr = wa; wdata = d1; wbe_n = b1;
        if (wr) model[wa] = {merge(model[wa][2*DW-1:DW], d1, b1), merge(model[wa][DW-1:0], d0, b0)};
    endtask

    // sample the two beats of a lone command, then the idle beat after
    task automatic collect(input bit ev, input logic [DW-1:0] e0, input logic [DW-1:0] e1, input string tag);
        repeat (RD_DLY) @(posedge clk_k);
        @(negedge clk_k); #3;
        check({tag, " R3 word0"}, rdata, ev ? e0 : '0);
        check({tag, " R4 valid beat0"}, rd_valid, ev);
        check("R9 echo_clk_n in beat0", echo_clk_n, 1'b1);
        check("R9 echo_clk in beat0", echo_clk, 1'b0);
        @(posedge clk_k); #3;
        check({tag, " R3 word1"}, rdata, ev ? e1 : '0);
        check({tag, " R4 valid beat1"}, rd_valid, ev);
        check("R9 echo_clk in beat1", echo_clk, 1'b1);
        @(negedge clk_k); #3;
        check("R4 valid after burst", rd_valid, 1'b0);
        check("R5 rdata zero after burst", rdata, '0);
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string tag);
        cyc(1, 0, a, a, '0, '0, '1, '1);
        collect(1, model[a][DW-1:0], model[a][2*DW-1:DW], tag);
    endtask

    initial begin
        #(P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements): got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2*DW-1:0] old;
        // R11 reset state
        repeat (3) @(posedge clk_k); #3;
        check("R11 valid in reset", rd_valid, 1'b0);
        check("R11 rdata in reset", rdata, '0);
        @(negedge clk_k); #2; rst_n = 1'b1;
        repeat (2) @(posedge clk_k); #3;
        check("R11 valid after reset", rd_valid, 1'b0);
        check("R11 rdata after reset", rdata, '0);
        // R9 idle echo
        @(negedge clk_k); #3;
        check("R9 idle echo_clk_n", echo_clk_n, 1'b1);
        @(posedge clk_k); #3;
        check("R9 idle echo_clk", echo_clk, 1'b1);
        check("R9 idle echo_clk_n low", echo_clk_n, 1'b0);

        // fill every location with full bursts (R1)
        for (int a = 0; a < 16; a++)
            cyc(0, 1, '0, AW'(a), DW'(a * 4369 + 7), DW'(a * 2731 + 99), '0, '0);
        read_chk(4'd2, "R1 fill");

        // vector table: R1 full writes, R2 lane writes
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            v = VEC[i];
            cyc(0, 1, '0, v[43:40], v[35:18], v[17:0], v[39:38], v[37:36]);
            read_chk(v[43:40], (v[39:36] == 4'b0000) ? "R1 vec" : "R2 vec");
        end

        // R6 same-period read and write
        old = model[5];
        cyc(1, 1, 4'd5, 4'd5, 18'h0BEEF, 18'h1CAFE, '0, '0);
        collect(1, old[DW-1:0], old[2*DW-1:DW], "R6 old data");
        read_chk(4'd5, "R6 new data");

        // R7 address and data ignored without a strobe
        cyc(0, 0, 4'd6, 4'd6, 18'h3FFFF, 18'h3FFFF, '0, '0);
        collect(0, '0, '0, "R7 no output");
        read_chk(4'd6, "R7 unchanged");

        // R10 back-to-back reads
        cyc(1, 0, 4'd3, 4'd0, '0, '0, '1, '1);
        cyc(1, 0, 4'd9, 4'd0, '0, '0, '1, '1);
        repeat (RD_DLY - 1) @(posedge clk_k);
        @(negedge clk_k); #3;
        check("R10 first word0", rdata, model[3][DW-1:0]);
        @(posedge clk_k); #3;
        check("R10 first word1", rdata, model[3][2*DW-1:DW]);
        @(negedge clk_k); #3;
        check("R10 second word0", rdata, model[9][DW-1:0]);
        check("R10 valid unbroken", rd_valid, 1'b1);
        @(posedge clk_k); #3;
        check("R10 second word1", rdata, model[9][2*DW-1:DW]);
        @(negedge clk_k); #3;
        check("R10 valid ends", rd_valid, 1'b0);

        // R8 switch to the lagging output pair under reset
        @(negedge clk_k); #2; rst_n = 1'b0;
        tied_mode = 1'b0;
        repeat (3) @(posedge clk_k);
        @(negedge clk_k); #2; rst_n = 1'b1;
        repeat (2) @(posedge clk_k);
        cyc(1, 0, 4'd7, 4'd0, '0, '0, '1, '1);
        repeat (RD_DLY) @(posedge clk_k);
        @(negedge clk_k); #1;
        check("R8 not yet valid before clk_cn", rd_valid, 1'b0);
        #2;
        check("R8 word0 on clk_cn", rdata, model[7][DW-1:0]);
        @(posedge clk_k); #1;
        check("R8 word0 held until clk_c", rdata, model[7][DW-1:0]);
        #2;
        check("R8 word1 on clk_c", rdata, model[7][2*DW-1:DW]);
        @(negedge clk_k); #3;
        check("R8 valid ends", rd_valid, 1'b0);
        read_chk(4'd0, "R8 lag");
        cyc(0, 1, '0, 4'd0, 18'h00ABC, 18'h3F000, 2'b01, 2'b10);
        read_chk(4'd0, "R2 lag");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule